// File: doc/BRIEF.md
# Cascadable Down-Counting Timer Array

The block holds six down-counting timers that share one system clock. Each timer has a reload latch and a small menu of count sources. The sources are prescaled clock enables, an edge detected on one of two external pins, the undivided sub-oscillator enable, and the overflow pulse of a fixed partner timer. Through the partner overflows, timers can be chained into prescaler pairs: 1 feeds 2, 3 feeds 4, either 2 or 4 feeds 5, and 5 feeds 6.

Software uses a simple single-cycle write bus to set the reload latches and the two source-select registers. A read returns the live counter value. Each timer produces a one-cycle overflow pulse. That pulse goes out as its interrupt request, and the same pulse serves as the cascade source inside the array.

The oscillators are outside the block. They appear as single-cycle enables `main_tick` and `sub_tick`, already in the system clock domain. The `base_is_sub` input chooses which of the two feeds the divider chain.

Top module: `cascade_timer_bank`

## Requirements
- R1: After reset every counter and latch holds all ones, both select registers read 0, and no `irq` bit is high.
- R2: A write to address k (0..5 for timers 1..6) loads both the latch and the counter of that timer at the same clock edge. Reading address k returns the live counter.
- R3: Each source tick lowers the counter by one. A tick that arrives while the counter is 0 reloads the latch value and raises that timer's `irq` bit for exactly one cycle. With latch value n this gives one overflow per n+1 ticks.
- R4: A latch write in the same cycle as a source tick takes priority: the counter takes the written value and no overflow is produced.
- R5: Timer 1 source field is select register A bits [1:0]: 0 = base/DIV_MID, 1 = base/DIV_SLOW, 2 = pin A rising edge, 3 = base/DIV_MID.
- R6: Timer 2 source field is register A bits [3:2]: 0 = base/DIV_MID, 1 = timer 1 overflow, 2 = pin A rising edge, 3 = base/DIV_MID.
- R7: Timer 3 source field is register A bits [5:4]: 0 = base/DIV_MID, 1 = `sub_tick` undivided, 2 = pin B rising edge, 3 = base/DIV_MID.
- R8: Timer 4 source field is register A bits [7:6]: 0 = base/DIV_MID, 1 = base/DIV_FAST, 2 = `sub_tick` undivided, 3 = timer 3 overflow.
- R9: Register B bits [1:0] select timer 5 (0 and 3 = base/DIV_MID, 1 = timer 2 overflow, 2 = timer 4 overflow). Register B bits [3:2] select timer 6 (1 = timer 5 overflow, others = base/DIV_MID). An overflow pulse counts one cycle after it appears on `irq`.
- R10: The divider chain counts `main_tick` when `base_is_sub` is 0 and `sub_tick` when it is 1. A /D enable fires on every D-th base tick after reset, the first on the D-th.
- R11: Each pin passes through SYNC_STAGES flops and then a rising-edge detector. Only a low-to-high change counts, and it counts once, no matter how long the pin stays high.
- R12: Register A is at address 6 and register B at address 7. Register B keeps only bits [3:0] and reads its upper bits as 0. Any address from 8 up reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | Main oscillator enable, one cycle per oscillator period |
| sub_tick | input | 1 | Sub oscillator enable, one cycle per oscillator period |
| base_is_sub | input | 1 | 1 selects sub_tick as the divider chain base |
| pin_a | input | 1 | External count pin for timers 1 and 2 (asynchronous) |
| pin_b | input | 1 | External count pin for timer 3 (asynchronous) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr (combinational) |
| irq | output | 6 | Per-timer one-cycle overflow pulse, bit 0 = timer 1 |

## Verification
The bench builds the array with DIV_SLOW lowered to 64, which brings the slow divider tap within reach: it fires often enough that timer 1 overflows many times within a short run. DIV_FAST stays at 2, DIV_MID at 16 and WIDTH at 8. Small latch values then let every cascade chain run through several reloads, including a two-stage chain feeding timer 6. A reference model counts base ticks and pin edges with integers and predicts every `irq` bit and the read data on every clock. The bench sweeps the read address continuously, so all six live counters and both select registers are compared.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

   localparam int unsigned NUM_TIMERS  = 6;
   localparam int unsigned SEL_W       = 2;
   localparam int unsigned ADDR_MODE_A = 6;
   localparam int unsigned ADDR_MODE_B = 7;

   typedef struct packed {
      logic fast;
      logic mid;
      logic slow;
   } ctb_pre_t;

   function automatic logic is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ctb_prescaler.sv
module ctb_prescaler
   import ctb_pkg::*;
#(
   parameter int unsigned DIV_FAST = 2,
   parameter int unsigned DIV_MID  = 16,
   parameter int unsigned DIV_SLOW = 4096
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     main_tick,
   input  logic     sub_tick,
   input  logic     base_is_sub,
   output ctb_pre_t pre
);

   localparam int unsigned PW = $clog2(DIV_SLOW);
   localparam logic [PW-1:0] M_FAST = PW'(DIV_FAST - 1);
   localparam logic [PW-1:0] M_MID  = PW'(DIV_MID - 1);
   localparam logic [PW-1:0] M_SLOW = PW'(DIV_SLOW - 1);

   initial begin
      a_div_pow2: assert (is_pow2(DIV_FAST) && is_pow2(DIV_MID) && is_pow2(DIV_SLOW))
         else $error("divider ratios must be powers of two");
      a_div_order: assert (DIV_FAST >= 2 && DIV_FAST <= DIV_MID && DIV_MID <= DIV_SLOW)
         else $error("divider ratios must satisfy 2 <= FAST <= MID <= SLOW");
   end

   logic          base;
   logic [PW-1:0] pcnt;

   assign base = base_is_sub ? sub_tick : main_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pcnt <= '0;
      else if (base) pcnt <= pcnt + PW'(1);
   end

   always_comb begin
      pre.fast = base && ((pcnt & M_FAST) == M_FAST);
      pre.mid  = base && ((pcnt & M_MID)  == M_MID);
      pre.slow = base && ((pcnt & M_SLOW) == M_SLOW);
   end

   // R10: the taps are nested, a slow tick is always also a mid and fast tick
   a_r10_slow_in_mid: assert property (@(posedge clk) disable iff (!rst_n)
      pre.slow |-> pre.mid);
   a_r10_mid_in_fast: assert property (@(posedge clk) disable iff (!rst_n)
      pre.mid |-> pre.fast);

endmodule

// File: rtl/ctb_edge_sync.sv
module ctb_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);

   initial begin
      a_stages_min: assert (STAGES >= 2)
         else $error("synchronizer needs at least two stages");
   end

   logic [STAGES:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-1:0], pin};
   end

   assign rise = shreg[STAGES-1] & ~shreg[STAGES];

   // R11: one pulse per rising edge, never two cycles in a row
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/ctb_down_timer.sv
module ctb_down_timer #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned SEL_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2**SEL_W-1:0]  src_opts,
   input  logic [SEL_W-1:0]     sel,
   input  logic                 wr_hit,
   input  logic [WIDTH-1:0]     wdata,
   output logic [WIDTH-1:0]     count,
   output logic                 ovf
);

   logic [WIDTH-1:0] latch;
   logic             tick;

   assign tick = src_opts[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch <= '1;
         count <= '1;
         ovf   <= 1'b0;
      end else begin
         ovf <= 1'b0;
         if (wr_hit) begin
            latch <= wdata;
            count <= wdata;
         end else if (tick) begin
            if (count == '0) begin
               count <= latch;
               ovf   <= 1'b1;
            end else begin
               count <= count - WIDTH'(1);
            end
         end
      end
   end

   // R2: a write lands in latch and counter together
   a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (count == $past(wdata)) && (latch == $past(wdata)));
   // R4: no overflow out of a write cycle
   a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> !ovf);
   // R3: a tick on a non-zero counter steps it down by one
   a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_hit && count != '0) |=> (count == $past(count) - WIDTH'(1)) && !ovf);
   // R3: an overflow cycle always shows the reloaded value
   a_r3_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (count == latch));
   // R3: without tick or write the counter holds
   a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_hit) |=> $stable(count) && !ovf);

endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank
   import ctb_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DIV_FAST    = 2,
   parameter int unsigned DIV_MID     = 16,
   parameter int unsigned DIV_SLOW    = 4096,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              main_tick,
   input  logic              sub_tick,
   input  logic              base_is_sub,
   input  logic              pin_a,
   input  logic              pin_b,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic [5:0]        irq
);

   localparam int unsigned NT       = NUM_TIMERS;
   localparam int unsigned NOPT     = 2**SEL_W;
   localparam int unsigned MODE_A_W = 4 * SEL_W;
   localparam int unsigned MODE_B_W = (NT - 4) * SEL_W;

   initial begin
      a_width_fits: assert (WIDTH >= MODE_A_W)
         else $error("data width must hold a select register");
      a_addr_fits: assert ((2**ADDR_W) > ADDR_MODE_B)
         else $error("address width too small for the register map");
   end

   ctb_pre_t            pre;
   logic                rise_a, rise_b;
   logic [MODE_A_W-1:0] mode_a;
   logic [MODE_B_W-1:0] mode_b;
   logic [NT-1:0]       ovf;
   logic [NT-1:0]       wr_hit;
   logic [WIDTH-1:0]    count [NT];
   logic [NOPT-1:0]     opts  [NT];
   logic [SEL_W-1:0]    sel   [NT];
   logic                mode_a_wr, mode_b_wr;

   ctb_prescaler #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_pre (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
      .base_is_sub(base_is_sub), .pre(pre)
   );

   ctb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .pin(pin_a), .rise(rise_a)
   );
   ctb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .pin(pin_b), .rise(rise_b)
   );

   // select register writes
   assign mode_a_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_MODE_A));
   assign mode_b_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_MODE_B));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_a <= '0;
         mode_b <= '0;
      end else begin
         if (mode_a_wr) mode_a <= bus_wdata[MODE_A_W-1:0];
         if (mode_b_wr) mode_b <= bus_wdata[MODE_B_W-1:0];
      end
   end

   // per-timer source menus, bit index = select code
   always_comb begin
      opts[0] = {pre.mid, rise_a,   pre.slow, pre.mid};
      opts[1] = {pre.mid, rise_a,   ovf[0],   pre.mid};
      opts[2] = {pre.mid, rise_b,   sub_tick, pre.mid};
      opts[3] = {ovf[2],  sub_tick, pre.fast, pre.mid};
      opts[4] = {pre.mid, ovf[3],   ovf[1],   pre.mid};
      opts[5] = {pre.mid, pre.mid,  ovf[4],   pre.mid};
   end

   generate
      for (genvar k = 0; k < NT; k++) begin : g_tmr
         if (k < 4) begin : g_sel_a
            assign sel[k] = mode_a[k*SEL_W +: SEL_W];
         end else begin : g_sel_b
            assign sel[k] = mode_b[(k-4)*SEL_W +: SEL_W];
         end
         assign wr_hit[k] = bus_wr && (bus_addr == ADDR_W'(k));
         ctb_down_timer #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .src_opts(opts[k]), .sel(sel[k]),
            .wr_hit(wr_hit[k]), .wdata(bus_wdata), .count(count[k]), .ovf(ovf[k])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NT; k++) begin
         if (bus_addr == ADDR_W'(k)) bus_rdata = count[k];
      end
      if (bus_addr == ADDR_W'(ADDR_MODE_A)) bus_rdata = WIDTH'(mode_a);
      if (bus_addr == ADDR_W'(ADDR_MODE_B)) bus_rdata = WIDTH'(mode_b);
   end

   assign irq = ovf;

   // R12: a select write is visible on the following cycle
   a_r12_mode_a_write: assert property (@(posedge clk) disable iff (!rst_n)
      mode_a_wr |=> mode_a == $past(bus_wdata[MODE_A_W-1:0]));
   // R6: a timer 2 overflow fed from timer 1 needs a timer 1 pulse one cycle earlier
   a_r6_cascade_origin: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ovf[1]) && $past(sel[1]) == SEL_W'(1) && !$past(wr_hit[1])) |-> $past(ovf[0]));

endmodule

// File: tb/tb_cascade_timer_bank.sv
module tb_cascade_timer_bank;

   localparam int W    = 8;
   localparam int AW   = 4;
   localparam int FAST = 2;
   localparam int MID  = 16;
   localparam int SLOW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          main_tick = 1'b0, sub_tick = 1'b0, base_is_sub = 1'b0;
   logic          pin_a = 1'b0, pin_b = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic [5:0]    irq;

   always #10 clk = ~clk;

   cascade_timer_bank #(.WIDTH(W), .ADDR_W(AW), .DIV_FAST(FAST), .DIV_MID(MID),
                        .DIV_SLOW(SLOW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
      .base_is_sub(base_is_sub), .pin_a(pin_a), .pin_b(pin_b), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // reference model state
   int    m_cnt [6];
   int    m_lat [6];
   bit    m_ovf [6];
   bit    n_ovf [6];
   bit    tk    [6];
   int    m_ma, m_mb, m_pc;
   bit    a1, a2, a3, b1, b2, b3;
   bit    base, f2, f16, fs, ra, rb;
   string tag = "R1";
   int    checks = 0, fails = 0;
   int    cyc = 0, rd_ptr = 0;
   bit    sub_hold = 0;
   bit    done = 0;

   function automatic bit pick(input int s, input bit o0, input bit o1, input bit o2, input bit o3);
      case (s & 3)
         0: return o0;
         1: return o1;
         2: return o2;
         default: return o3;
      endcase
   endfunction

   always @(posedge clk) begin : model
      logic [5:0] e_irq;
      int         e_rd;
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) begin
            m_cnt[i] = 255; m_lat[i] = 255; m_ovf[i] = 0;
         end
         m_ma = 0; m_mb = 0; m_pc = 0;
         {a1, a2, a3, b1, b2, b3} = '0;
      end else begin
         base = base_is_sub ? sub_tick : main_tick;
         f2  = base && (m_pc % FAST == FAST - 1);
         f16 = base && (m_pc % MID  == MID - 1);
         fs  = base && (m_pc % SLOW == SLOW - 1);
         if (base) m_pc = (m_pc + 1) % SLOW;
         ra = a2 && !a3; rb = b2 && !b3;
         a3 = a2; a2 = a1; a1 = pin_a;
         b3 = b2; b2 = b1; b1 = pin_b;
         tk[0] = pick(m_ma,      f16, fs,        ra,        f16);
         tk[1] = pick(m_ma >> 2, f16, m_ovf[0],  ra,        f16);
         tk[2] = pick(m_ma >> 4, f16, sub_tick,  rb,        f16);
         tk[3] = pick(m_ma >> 6, f16, f2,        sub_tick,  m_ovf[2]);
         tk[4] = pick(m_mb,      f16, m_ovf[1],  m_ovf[3],  f16);
         tk[5] = pick(m_mb >> 2, f16, m_ovf[4],  f16,       f16);
         for (int i = 0; i < 6; i++) begin
            n_ovf[i] = 0;
            if (bus_wr && bus_addr == AW'(i)) begin
               m_lat[i] = bus_wdata; m_cnt[i] = bus_wdata;
            end else if (tk[i]) begin
               if (m_cnt[i] == 0) begin
                  m_cnt[i] = m_lat[i]; n_ovf[i] = 1;
               end else m_cnt[i] = m_cnt[i] - 1;
            end
         end
         for (int i = 0; i < 6; i++) m_ovf[i] = n_ovf[i];
         if (bus_wr && bus_addr == 4'd6) m_ma = bus_wdata;
         if (bus_wr && bus_addr == 4'd7) m_mb = bus_wdata & 15;
      end
      #5;
      if (!done) begin
         for (int i = 0; i < 6; i++) e_irq[i] = m_ovf[i];
         if (bus_addr < 6)       e_rd = m_cnt[bus_addr];
         else if (bus_addr == 6) e_rd = m_ma;
         else if (bus_addr == 7) e_rd = m_mb;
         else                    e_rd = 0;
         checks++;
         if (irq !== e_irq) begin
            fails++;
            $display("FAIL %s irq: actual %b expected %b (cycle %0d)", tag, irq, e_irq, cyc);
         end
         checks++;
         if (bus_rdata !== W'(e_rd)) begin
            fails++;
            $display("FAIL %s read addr %0d: actual %0d expected %0d (cycle %0d)",
                     tag, bus_addr, bus_rdata, e_rd, cyc);
         end
      end
   end

   task automatic drive_bg();
      cyc++;
      main_tick = (cyc % 5) != 4;
      sub_tick  = sub_hold ? 1'b1 : (cyc % 3 == 0);
      pin_a     = (cyc % 7) < 3;
      pin_b     = (cyc % 5) < 2;
      bus_addr  = AW'(rd_ptr);
      rd_ptr    = (rd_ptr + 1) % 10;
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(negedge clk);
         bus_wr = 1'b0;
         drive_bg();
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      drive_bg();
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = W'(d);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : stim
      tag = "R1"; step(4);
      rst_n = 1'b1; step(12);
      tag = "R12"; wr(6, 0); wr(7, 8'hFF); step(12); wr(7, 0); step(10);
      tag = "R2"; wr(0, 3); step(4);
      tag = "R3"; step(120); wr(0, 0); step(60);
      tag = "R5"; wr(6, 8'h01); wr(0, 1); step(400);
      tag = "R11"; wr(6, 8'h02); step(120);
      tag = "R6"; wr(6, 8'h04); wr(0, 2); wr(1, 3); step(300);
      wr(6, 8'h08); step(100);
      tag = "R7"; wr(6, 8'h10); wr(2, 4); step(60); wr(6, 8'h20); step(100);
      tag = "R8"; wr(6, 8'h40); wr(3, 5); step(60); wr(6, 8'h80); step(60);
      wr(6, 8'hC0); wr(2, 1); wr(3, 2); step(300);
      tag = "R9"; wr(6, 8'h04); wr(0, 1); wr(1, 1); wr(7, 8'h01); wr(4, 2); step(200);
      wr(6, 8'h40); wr(7, 8'h02); step(200);
      wr(7, 8'h05); wr(4, 1); wr(5, 1); step(300);
      tag = "R10"; base_is_sub = 1'b1; wr(6, 0); wr(7, 0); wr(0, 2); step(300);
      base_is_sub = 1'b0; step(40);
      tag = "R4"; sub_hold = 1; wr(6, 8'h10); wr(2, 0); step(5);
      wr(2, 0); wr(2, 0); wr(2, 2); step(10); wr(2, 1); step(3);
      sub_hold = 0; step(10);
      finish_run();
   end

endmodule